// File: doc/BRIEF.md
# Quadrature Position Counter Channel

This block is one position-counting channel fed by the two outputs of an incremental encoder, phase A and phase B. Both inputs are brought into the clock domain through flop synchronisers. A small phase state machine then compares each sampled A/B pair with the previous one and turns the change into a count step and a direction. Three counting rules can be selected: four counts per encoder cycle from every edge of both phases, one count per rising edge of A with B giving the direction, and two counts per cycle from the edges of B only.

A compare register sets a ceiling for the count. A clear-source field chooses between two behaviours. In the first, counting up past the compare value returns to zero and counting down from zero reloads the compare value. In the second, the counter wraps freely over its full width. A status bit shows the direction of the most recent counted step. The parameter `CNT_W` sets the count width: 16 bits is a single channel, and 32 bits stands for two channels cascaded into one count. Software reaches the count, mode, control, compare, status and enable registers through a simple single-cycle register bus.

The phase state machine has four states, named after the sampled {A,B} pair: PH_00, PH_10, PH_11 and PH_01. The forward transitions are PH_00→PH_10→PH_11→PH_01→PH_00, the order in which A leads B, and they count up. The reverse transitions run the opposite way and count down. A jump to the diagonal state, where both phases changed in one sample, is the invalid transition and produces no step. A transition from a state to itself produces no step either.

Top module: `qpc_timer`

Register map (word addresses on `bus_addr`): 0 count (read/write, `CNT_W` bits), 1 mode (bits 3:0), 2 control (clear source in bits 7:5), 3 compare (`CNT_W` bits), 4 status (bit 7 direction, read only), 5 enable (bit 0). Unused bits read as zero.

## Requirements
- R1: After reset the registers read as follows: count 0, mode 4, control 0x20 (clear source 1), compare all ones for `CNT_W`, enable 0, status 0.
- R2: Mode code 4 is the x4 rule. Each single-phase change of A or B counts one step. The step is up on a forward transition (00→10→11→01→00 as {A,B}) and down on a reverse transition.
- R3: Mode code 5 is the pulse/direction rule. Only a rising edge of A with B steady counts. B high selects up and B low selects down.
- R4: Mode code 7 is the x2 rule on B. Only a change of B with A steady counts. After the change, B equal to A means up and B different from A means down.
- R5: A sample in which A and B both changed leaves the count unchanged in every mode.
- R6: Mode codes other than 4, 5 and 7 leave the count unchanged for any input change.
- R7: With clear source 1, an up step from a count equal to compare gives 0. A down step from 0 gives the compare value.
- R8: With clear source 0, the count wraps freely: an up step from all ones gives 0, and a down step from 0 gives all ones, whatever the compare value.
- R9: Status bit 7 reads 1 after a counted up step and 0 after a counted down step.
- R10: With enable bit 0 cleared, input changes leave the count unchanged.
- R11: A bus write to the count takes effect on the next clock and wins over a count step in the same cycle.
- R12: An input change shows in the count on the third rising clock edge after it is applied, and not on the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enc_a | input | 1 | Encoder phase A, asynchronous |
| enc_b | input | 1 | Encoder phase B, asynchronous |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, combinational from bus_addr |

## Verification
The decoder is swept over every pair of previous and new {A,B} states under each of the three counting codes and one unused code, with the count preloaded to a mid value. The full transition table is therefore checked in every mode. Forward, reverse, self and diagonal transitions are told apart, which separates a wrong direction, a missed step, a spurious step and a double-change that should be rejected. Separate patterns drive the count to the compare value and to zero, with clearing enabled and disabled, to tell ceiling clearing from free wrap. Further patterns check enable gating, the precedence of a write over a step in the same cycle, and the exact synchroniser latency.

// File: rtl/qpc_pkg.sv
package qpc_pkg;

    typedef enum logic [1:0] {
        PH_00 = 2'b00,
        PH_01 = 2'b01,
        PH_10 = 2'b10,
        PH_11 = 2'b11
    } phase_t;

    localparam logic [3:0] MODE_X4  = 4'd4;
    localparam logic [3:0] MODE_PD  = 4'd5;
    localparam logic [3:0] MODE_X2B = 4'd7;

    localparam logic [2:0] CLR_NONE = 3'd0;
    localparam logic [2:0] CLR_CMPA = 3'd1;

    localparam int REG_CNT  = 0;
    localparam int REG_MODE = 1;
    localparam int REG_CTRL = 2;
    localparam int REG_CMP  = 3;
    localparam int REG_STAT = 4;
    localparam int REG_EN   = 5;

    localparam int CLR_LSB  = 5;
    localparam int DIR_BIT  = 7;

endpackage

// File: rtl/qpc_sync.sv
module qpc_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/qpc_decode.sv
module qpc_decode
    import qpc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] ab,       // synchronised {A,B}
    input  logic [3:0] mode,
    output logic [1:0] prev_ab,
    output logic       step,
    output logic       step_up
);
    phase_t ph_q;
    phase_t ph_cur;
    phase_t ph_fwd;
    phase_t ph_rev;
    logic   ch_a, ch_b;

    assign ph_cur  = phase_t'(ab);
    assign prev_ab = ph_q;

    // state register: follows the sampled pair every cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ph_q <= PH_00;
        else        ph_q <= ph_cur;
    end

    // neighbour states of the present state
    always_comb begin
        unique case (ph_q)
            PH_00: begin ph_fwd = PH_10; ph_rev = PH_01; end
            PH_10: begin ph_fwd = PH_11; ph_rev = PH_00; end
            PH_11: begin ph_fwd = PH_01; ph_rev = PH_10; end
            PH_01: begin ph_fwd = PH_00; ph_rev = PH_11; end
            default: begin ph_fwd = PH_00; ph_rev = PH_00; end
        endcase
    end

    // output process
    always_comb begin
        ch_a    = ab[1] ^ ph_q[1];
        ch_b    = ab[0] ^ ph_q[0];
        step    = 1'b0;
        step_up = 1'b0;
        if (!(ch_a && ch_b)) begin
            case (mode)
                MODE_X4: begin
                    step    = (ph_cur == ph_fwd) || (ph_cur == ph_rev);
                    step_up = (ph_cur == ph_fwd);
                end
                MODE_PD: begin
                    step    = ch_a && ab[1];
                    step_up = ab[0];
                end
                MODE_X2B: begin
                    step    = ch_b;
                    step_up = (ph_cur == ph_fwd);
                end
                default: begin
                    step    = 1'b0;
                    step_up = 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/qpc_count.sv
module qpc_count
    import qpc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             step,
    input  logic             up,
    input  logic [2:0]       clr_sel,
    input  logic [CNT_W-1:0] cmp,
    input  logic             wr,
    input  logic [CNT_W-1:0] wval,
    output logic [CNT_W-1:0] cnt,
    output logic             dir
);
    logic             clr_on;
    logic [CNT_W-1:0] cnt_d;

    assign clr_on = (clr_sel == CLR_CMPA);

    always_comb begin
        cnt_d = cnt;
        if (wr) begin
            cnt_d = wval;
        end else if (en && step) begin
            if (up) cnt_d = (clr_on && cnt == cmp) ? '0 : cnt + 1'b1;
            else    cnt_d = (clr_on && cnt == '0) ? cmp : cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            dir <= 1'b0;
        end else begin
            cnt <= cnt_d;
            if (en && step) dir <= up;
        end
    end
endmodule

// File: rtl/qpc_timer.sv
module qpc_timer
    import qpc_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int DATA_W      = 32,
    parameter int ADDR_W      = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enc_a,
    input  logic              enc_b,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata
);
    logic [3:0]       mode_q;
    logic [2:0]       clr_q;
    logic [CNT_W-1:0] cmp_q;
    logic             en_q;
    logic [1:0]       ab_s;
    logic [1:0]       ab_prev;
    logic             step, step_up;
    logic [CNT_W-1:0] cnt_v;
    logic             dir_v;
    logic             cnt_wr;
    logic [CNT_W-1:0] cnt_wval;

    function automatic logic hit(input logic [ADDR_W-1:0] a, input int r);
        return bus_we && (a == ADDR_W'(r));
    endfunction

    assign cnt_wr   = hit(bus_addr, REG_CNT);
    assign cnt_wval = bus_wdata[CNT_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= MODE_X4;
            clr_q  <= CLR_CMPA;
            cmp_q  <= '1;
            en_q   <= 1'b0;
        end else begin
            if (hit(bus_addr, REG_MODE)) mode_q <= bus_wdata[3:0];
            if (hit(bus_addr, REG_CTRL)) clr_q  <= bus_wdata[CLR_LSB+2:CLR_LSB];
            if (hit(bus_addr, REG_CMP))  cmp_q  <= bus_wdata[CNT_W-1:0];
            if (hit(bus_addr, REG_EN))   en_q   <= bus_wdata[0];
        end
    end

    qpc_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst_n(rst_n),
        .d   ({enc_a, enc_b}),
        .q   (ab_s)
    );

    qpc_decode u_dec (
        .clk    (clk),
        .rst_n  (rst_n),
        .ab     (ab_s),
        .mode   (mode_q),
        .prev_ab(ab_prev),
        .step   (step),
        .step_up(step_up)
    );

    qpc_count #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (en_q),
        .step   (step),
        .up     (step_up),
        .clr_sel(clr_q),
        .cmp    (cmp_q),
        .wr     (cnt_wr),
        .wval   (cnt_wval),
        .cnt    (cnt_v),
        .dir    (dir_v)
    );

    always_comb begin
        bus_rdata = '0;
        case (int'(bus_addr))
            REG_CNT:  bus_rdata[CNT_W-1:0] = cnt_v;
            REG_MODE: bus_rdata[3:0] = mode_q;
            REG_CTRL: bus_rdata[CLR_LSB+2:CLR_LSB] = clr_q;
            REG_CMP:  bus_rdata[CNT_W-1:0] = cmp_q;
            REG_STAT: bus_rdata[DIR_BIT] = dir_v;
            REG_EN:   bus_rdata[0] = en_q;
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/qpc_timer_chk.sv
module qpc_timer_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] cmp,
    input logic [3:0]       mode,
    input logic [2:0]       clr,
    input logic             en,
    input logic             wr,
    input logic [CNT_W-1:0] wval,
    input logic             step,
    input logic             up,
    input logic             dir,
    input logic [1:0]       ab,
    input logic [1:0]       ab_prev
);
    AST_DOUBLE_CHANGE_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ab[1] != ab_prev[1] && ab[0] != ab_prev[0]) |-> !step); // R5

    AST_BAD_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != 4'd4 && mode != 4'd5 && mode != 4'd7 && !wr) |=> $stable(cnt)); // R6

    AST_UP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (en && step && up && clr == 3'd1 && cnt == cmp && !wr) |=> cnt == '0); // R7

    AST_DOWN_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (en && step && !up && clr == 3'd1 && cnt == '0 && !wr) |=> cnt == $past(cmp)); // R7

    AST_DIR_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        (en && step) |=> dir == $past(up)); // R9

    AST_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !wr) |=> $stable(cnt)); // R10

    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> cnt == $past(wval)); // R11
endmodule

bind qpc_timer qpc_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .cnt    (cnt_v),
    .cmp    (cmp_q),
    .mode   (mode_q),
    .clr    (clr_q),
    .en     (en_q),
    .wr     (cnt_wr),
    .wval   (cnt_wval),
    .step   (step),
    .up     (step_up),
    .dir    (dir_v),
    .ab     (ab_s),
    .ab_prev(ab_prev)
);

// File: tb/qpc_timer_bench.sv
module qpc_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enc_a = 1'b0, enc_b = 1'b0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    qpc_timer #(.CNT_W(16)) u_qpc_timer (
        .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = 3'(a); bus_wdata = d;
        @(posedge clk); #1;
        bus_we = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = 3'(a);
        #1 d = bus_rdata;
    endtask

    task automatic move(input logic na, input logic nb);
        @(negedge clk);
        enc_a = na; enc_b = nb;
        repeat (5) @(posedge clk);
    endtask

    // expected step (+1, -1, 0) from encoder rules
    function automatic int delta(input int m, input logic pa, input logic pb,
                                 input logic ca, input logic cb);
        logic da, db;
        da = pa ^ ca; db = pb ^ cb;
        if (da && db) return 0;
        if (m == 4) begin
            if (da) return (ca != cb) ? 1 : -1;
            if (db) return (ca == cb) ? 1 : -1;
            return 0;
        end
        if (m == 5) return (da && ca) ? (cb ? 1 : -1) : 0;
        if (m == 7) return db ? ((ca == cb) ? 1 : -1) : 0;
        return 0;
    endfunction

    initial begin
        repeat (400000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int modes [4] = '{4, 5, 7, 3};
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(0, v); check("R1 count", v, 32'h0);
        rd(1, v); check("R1 mode", v, 32'h4);
        rd(2, v); check("R1 ctrl", v, 32'h20);
        rd(3, v); check("R1 cmp", v, 32'hFFFF);
        rd(4, v); check("R1 status", v, 32'h0);
        rd(5, v); check("R1 enable", v, 32'h0);

        // full transition sweep: R2 R3 R4 R5 R6 R9
        foreach (modes[mi]) begin
            for (int f = 0; f < 4; f++) begin
                for (int t = 0; t < 4; t++) begin
                    int d;
                    string tag;
                    logic pa, pb, ca, cb;
                    pa = f[1]; pb = f[0]; ca = t[1]; cb = t[0];
                    d = delta(modes[mi], pa, pb, ca, cb);
                    if ((pa ^ ca) && (pb ^ cb)) tag = "R5";
                    else if (modes[mi] == 3) tag = "R6";
                    else if (modes[mi] == 4) tag = "R2";
                    else if (modes[mi] == 5) tag = "R3";
                    else tag = "R4";
                    wr(5, 0);
                    wr(1, modes[mi]);
                    move(pa, pb);
                    wr(0, 100);
                    wr(5, 1);
                    move(ca, cb);
                    rd(0, v);
                    check(tag, v, 32'(100 + d));
                    if (d != 0) begin
                        rd(4, v);
                        check("R9 direction", v, (d > 0) ? 32'h80 : 32'h0);
                    end
                end
            end
        end

        // ceiling with clear source 1 (R7); inputs now 11, mode 3
        wr(5, 0); wr(1, 4); move(0, 0);
        wr(3, 10); wr(2, 32'h20); wr(0, 10); wr(5, 1);
        move(1, 0);
        rd(0, v); check("R7 up clear", v, 32'h0);
        move(0, 0);
        rd(0, v); check("R7 down reload", v, 32'd10);

        // clear source 0 (R8)
        wr(2, 0); wr(0, 10);
        move(1, 0);
        rd(0, v); check("R8 pass cmp", v, 32'd11);
        wr(0, 0);
        move(0, 0);
        rd(0, v); check("R8 down wrap", v, 32'hFFFF);
        move(1, 0);
        rd(0, v); check("R8 up wrap", v, 32'h0);

        // enable gating (R10)
        wr(0, 7); wr(5, 0);
        move(1, 1);
        rd(0, v); check("R10 disabled", v, 32'd7);
        wr(5, 1);
        move(1, 0);
        rd(0, v); check("R10 re-enabled down", v, 32'd6);

        // latency (R12): inputs at 10, forward to 11
        @(negedge clk); enc_a = 1'b1; enc_b = 1'b1;
        @(posedge clk); @(posedge clk);
        rd(0, v); check("R12 second edge", v, 32'd6);
        @(posedge clk); #1;
        bus_addr = 3'(0); #1 v = bus_rdata;
        check("R12 third edge", v, 32'd7);

        // write wins over step in same cycle (R11): 11 -> 01 forward
        @(negedge clk); enc_a = 1'b0;
        @(posedge clk); @(posedge clk);
        @(negedge clk); bus_we = 1'b1; bus_addr = 3'(0); bus_wdata = 32'd55;
        @(posedge clk); #1 bus_we = 1'b0;
        repeat (3) @(posedge clk);
        rd(0, v); check("R11 write wins", v, 32'd55);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule